// File: doc/BRIEF.md
# Word-Level Crosspoint Switch with Burst Map Loader

This block routes word-wide data from any of its inputs to any of its outputs. Each output has its own source select and its own force-idle flag. When the flag is set, the output sends a fixed idle word instead of the routed input. Every output is registered. An output therefore shows, one clock after an edge, the input word it sampled at that edge.

The routing map is reloaded through a narrow parallel port in a short burst. While the active-low configure enable is held low, a strobe marks the first beat of a load. That beat and the three beats that follow each carry the source selects and force-idle bits for one group of four outputs. The beats are collected in a shadow map. After the last beat is captured, the whole shadow map is copied into the active map in a single cycle, so no output is ever steered by a partly written map.

A load that is interrupted is dropped and the active map keeps its previous contents. A load is interrupted when the enable rises, or when a fresh strobe restarts the sequence.

Top module: `xpt_cfg_switch`

## Requirements
- R1: Each output o carries the word of input `sel[o]`, where `sel[o]` is the source select held for o in the active map, for any pairing of outputs and sources, including several outputs sharing one source.
- R2: While `cfg_en_n` is high, `cfg_strobe`, `cfg_sel_bus` and `cfg_idle_bus` have no effect on the active map.
- R3: A load consists of the beat presented with `cfg_strobe` high and `cfg_en_n` low, followed by three further beats on the next three cycles. Beat data present while no load is in progress is ignored.
- R4: Beat k sets outputs 4k to 4k+3. Output 4k+j takes its select from `cfg_sel_bus[4j+3:4j]` and its force-idle flag from `cfg_idle_bus[j]`.
- R5: The active map changes in a single cycle, one cycle after the fourth beat is captured. The output registers show the new routing from the following edge on, and no output shows it earlier.
- R6: An output whose force-idle flag is 1 emits `IDLE_WORD` (default 16'hF00D), whatever its inputs are.
- R7: Reset (synchronous, active high) clears all outputs to zero and restores the map to output i from input i with no forced outputs.
- R8: If `cfg_en_n` goes high before the fourth beat, the partial load is dropped. The load does not resume when the enable returns low without a strobe.
- R9: A strobe arriving during a load drops the partial load and begins a new load at beat 0.
- R10: Outputs are registered with one cycle of latency: a change of the input words appears at the outputs after the next clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_n | input | 1 | Configure enable, active low |
| cfg_strobe | input | 1 | Marks beat 0 of a map load |
| cfg_sel_bus | input | 16 | Four 4-bit source selects for the current beat |
| cfg_idle_bus | input | 4 | Four force-idle flags for the current beat |
| in_words | input | 256 | Sixteen 16-bit input words, input i at bits [16i+15:16i] |
| out_words | output | 256 | Sixteen 16-bit output words, output o at bits [16o+15:16o] |

## Verification
The bench builds the switch with its default parameters: sixteen ports, 16-bit words, four outputs per beat and an idle word of 16'hF00D. These values let one 16-bit select bus cover every source nibble from 0 to 15, and a load needs all four beat positions. The idle word differs from every input pattern the bench drives. The map table reaches reversed, broadcast, rotated and fully idle routings. The directed cases then place enable drops and restart strobes at positions in the burst where a wrong beat count would commit a map early or late.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  localparam logic [15:0] XPT_IDLE_DEFAULT = 16'hF00D;

  function automatic int unsigned xpt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xpt_cfg_loader.sv
module xpt_cfg_loader
  import xpt_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned LANES     = 4,
  localparam int unsigned NUM_BEATS = NUM_PORTS / LANES,
  localparam int unsigned BEAT_W    = xpt_width(NUM_BEATS),
  localparam int unsigned BUS_W     = LANES * SEL_W
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cfg_en_n,
  input  logic                                 cfg_strobe,
  input  logic [BUS_W-1:0]                     cfg_sel_bus,
  input  logic [LANES-1:0]                     cfg_idle_bus,
  output logic [NUM_PORTS-1:0][SEL_W-1:0]      shadow_sel,
  output logic [NUM_PORTS-1:0]                 shadow_idle,
  output logic                                 commit
);

  logic              busy;
  logic [BEAT_W-1:0] beat_cnt;
  logic [BEAT_W-1:0] cur_beat;
  logic              take;
  logic              last_beat;

  // A strobe always restarts at beat 0; otherwise continue the running count
  always_comb begin
    cur_beat  = cfg_strobe ? '0 : beat_cnt;
    take      = !cfg_en_n && (cfg_strobe || busy);
    last_beat = (cur_beat == BEAT_W'(NUM_BEATS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      beat_cnt <= '0;
      commit   <= 1'b0;
    end else begin
      busy     <= take && !last_beat;
      beat_cnt <= (take && !last_beat) ? cur_beat + BEAT_W'(1) : '0;
      commit   <= take && last_beat;
    end
  end

  // Shadow map: one slot per output, written by the beat that owns it
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
    localparam int unsigned BEAT = p / LANES;
    localparam int unsigned LANE = p % LANES;
    always_ff @(posedge clk) begin
      if (take && (cur_beat == BEAT_W'(BEAT))) begin
        shadow_sel[p]  <= cfg_sel_bus[LANE*SEL_W +: SEL_W];
        shadow_idle[p] <= cfg_idle_bus[LANE];
      end
    end
  end

  AST_OFF_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    cfg_en_n |=> !commit and !busy);                                     // R2

  if (NUM_BEATS > 1) begin : g_multi
    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
      commit |=> !commit);                                               // R3
    AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en_n && cfg_strobe) |=> (!commit && busy));                  // R9
  end

endmodule

// File: rtl/xpt_map_regs.sv
module xpt_map_regs #(
  parameter int unsigned NUM_PORTS = 16,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            commit,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0] shadow_sel,
  input  logic [NUM_PORTS-1:0]            shadow_idle,
  output logic [NUM_PORTS-1:0][SEL_W-1:0] act_sel,
  output logic [NUM_PORTS-1:0]            act_idle
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        act_sel[p]  <= SEL_W'(p);
        act_idle[p] <= 1'b0;
      end else if (commit) begin
        act_sel[p]  <= shadow_sel[p];
        act_idle[p] <= shadow_idle[p];
      end
    end
  end

  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_sel) && $stable(act_idle)));                // R5

  AST_RESET_MAP: assert property (@(posedge clk)
    rst |=> (act_idle == '0));                                           // R7

endmodule

// File: rtl/xpt_mux_array.sv
module xpt_mux_array #(
  parameter int unsigned     NUM_PORTS = 16,
  parameter int unsigned     SEL_W     = 4,
  parameter int unsigned     WORD_W    = 16,
  parameter logic [WORD_W-1:0] IDLE_WORD = '0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0]  act_sel,
  input  logic [NUM_PORTS-1:0]             act_idle,
  input  logic [NUM_PORTS-1:0][WORD_W-1:0] in_arr,
  output logic [NUM_PORTS-1:0][WORD_W-1:0] out_arr
);

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        out_arr[o] <= '0;
      end else if (act_idle[o]) begin
        out_arr[o] <= IDLE_WORD;
      end else begin
        out_arr[o] <= in_arr[act_sel[o]];
      end
    end

    AST_FORCED_IDLE: assert property (@(posedge clk) disable iff (rst)
      act_idle[o] |=> (out_arr[o] == IDLE_WORD));                        // R6
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (out_arr == '0));                                            // R7

endmodule

// File: rtl/xpt_cfg_switch.sv
module xpt_cfg_switch
  import xpt_pkg::*;
#(
  parameter int unsigned       NUM_PORTS = 16,
  parameter int unsigned       WORD_W    = 16,
  parameter int unsigned       LANES     = 4,
  parameter logic [WORD_W-1:0] IDLE_WORD = WORD_W'(XPT_IDLE_DEFAULT),
  localparam int unsigned      SEL_W     = xpt_width(NUM_PORTS),
  localparam int unsigned      BUS_W     = LANES * SEL_W,
  localparam int unsigned      DATA_W    = NUM_PORTS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en_n,
  input  logic              cfg_strobe,
  input  logic [BUS_W-1:0]  cfg_sel_bus,
  input  logic [LANES-1:0]  cfg_idle_bus,
  input  logic [DATA_W-1:0] in_words,
  output logic [DATA_W-1:0] out_words
);

  logic [NUM_PORTS-1:0][SEL_W-1:0]  shadow_sel;
  logic [NUM_PORTS-1:0]             shadow_idle;
  logic [NUM_PORTS-1:0][SEL_W-1:0]  act_sel;
  logic [NUM_PORTS-1:0]             act_idle;
  logic [NUM_PORTS-1:0][WORD_W-1:0] in_arr;
  logic [NUM_PORTS-1:0][WORD_W-1:0] out_arr;
  logic                             commit;

  assign in_arr    = in_words;
  assign out_words = out_arr;

  xpt_cfg_loader #(
    .NUM_PORTS (NUM_PORTS),
    .SEL_W     (SEL_W),
    .LANES     (LANES)
  ) u_loader (
    .clk          (clk),
    .rst          (rst),
    .cfg_en_n     (cfg_en_n),
    .cfg_strobe   (cfg_strobe),
    .cfg_sel_bus  (cfg_sel_bus),
    .cfg_idle_bus (cfg_idle_bus),
    .shadow_sel   (shadow_sel),
    .shadow_idle  (shadow_idle),
    .commit       (commit)
  );

  xpt_map_regs #(
    .NUM_PORTS (NUM_PORTS),
    .SEL_W     (SEL_W)
  ) u_map (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit),
    .shadow_sel  (shadow_sel),
    .shadow_idle (shadow_idle),
    .act_sel     (act_sel),
    .act_idle    (act_idle)
  );

  xpt_mux_array #(
    .NUM_PORTS (NUM_PORTS),
    .SEL_W     (SEL_W),
    .WORD_W    (WORD_W),
    .IDLE_WORD (IDLE_WORD)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .act_sel  (act_sel),
    .act_idle (act_idle),
    .in_arr   (in_arr),
    .out_arr  (out_arr)
  );

  // Routing of output 0 follows the map with a single register stage
  AST_ROUTE_PORT0: assert property (@(posedge clk) disable iff (rst)
    !act_idle[0] |=> (out_arr[0] == $past(in_arr[act_sel[0]])));      // R1

endmodule

// File: tb/xpt_cfg_switch_bench.sv
module xpt_cfg_switch_bench;

  localparam logic [15:0] IDLE = 16'hF00D;

  // Vector layout: [15:0] beat0 .. [63:48] beat3, [79:64] idle bit per output
  localparam logic [79:0] VEC [6] = '{
    80'h0000_0123_4567_89AB_CDEF,   // reversed
    80'h0000_5555_5555_5555_5555,   // broadcast input 5
    80'h5555_FFFF_FFFF_FFFF_FFFF,   // input 15, even outputs idle
    80'h8001_0FED_CBA9_8765_4321,   // rotate by one, ends idle
    80'hFFFF_3333_2222_1111_0000,   // all idle
    80'h0000_FEDC_BA98_7654_3210    // identity
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         cfg_en_n;
  logic         cfg_strobe;
  logic [15:0]  cfg_sel_bus;
  logic [3:0]   cfg_idle_bus;
  logic [15:0][15:0] in_arr;
  logic [255:0] in_words;
  logic [255:0] out_words;

  logic [3:0]   m_sel  [16];
  logic         m_idle [16];
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  assign in_words = in_arr;

  xpt_cfg_switch #(.IDLE_WORD(IDLE)) u_xpt_cfg_switch (
    .clk          (clk),
    .rst          (rst),
    .cfg_en_n     (cfg_en_n),
    .cfg_strobe   (cfg_strobe),
    .cfg_sel_bus  (cfg_sel_bus),
    .cfg_idle_bus (cfg_idle_bus),
    .in_words     (in_words),
    .out_words    (out_words)
  );

  function automatic logic [255:0] exp_out();
    logic [255:0] r;
    for (int o = 0; o < 16; o++)
      r[o*16 +: 16] = m_idle[o] ? IDLE : in_arr[m_sel[o]];
    return r;
  endfunction

  task automatic set_inputs(input logic [7:0] seed);
    for (int i = 0; i < 16; i++) in_arr[i] = {seed, 4'(i), 4'h5};
  endtask

  task automatic model_identity();
    for (int o = 0; o < 16; o++) begin
      m_sel[o] = 4'(o);
      m_idle[o] = 1'b0;
    end
  endtask

  task automatic model_load(input logic [79:0] v);
    for (int o = 0; o < 16; o++) begin
      m_sel[o]  = v[o*4 +: 4];
      m_idle[o] = v[64 + o];
    end
  endtask

  task automatic check_vec(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_beat(input logic strobe, input logic [79:0] v, input int k);
    @(negedge clk);
    cfg_en_n     = 1'b0;
    cfg_strobe   = strobe;
    cfg_sel_bus  = v[k*16 +: 16];
    cfg_idle_bus = v[64 + k*4 +: 4];
  endtask

  task automatic go_quiet();
    @(negedge clk);
    cfg_en_n   = 1'b1;
    cfg_strobe = 1'b0;
  endtask

  // Full load; checks old map just before commit shows, then new map (R5)
  task automatic full_load(input logic [79:0] v, input string req);
    drive_beat(1'b1, v, 0);
    for (int k = 1; k < 4; k++) drive_beat(1'b0, v, k);
    go_quiet();
    @(negedge clk);
    check_vec("R5 old map until commit", out_words, exp_out());
    model_load(v);
    @(negedge clk);
    check_vec(req, out_words, exp_out());
  endtask

  initial begin
    rst = 1'b1; cfg_en_n = 1'b1; cfg_strobe = 1'b0;
    cfg_sel_bus = '0; cfg_idle_bus = '0;
    set_inputs(8'h31);
    model_identity();
    repeat (3) @(negedge clk);
    check_vec("R7 outputs zero in reset", out_words, '0);
    rst = 1'b0;
    @(negedge clk);
    check_vec("R7 identity map after reset", out_words, exp_out());

    // Table of maps, walked by one loop (R1 R4 R6)
    for (int v = 0; v < 6; v++) begin
      set_inputs(8'h40 + 8'(v));
      full_load(VEC[v], "R1/R4/R6 map table");
    end

    // R2: strobes and data with enable high
    load_model_dummy();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      cfg_en_n = 1'b1; cfg_strobe = (c % 2 == 0);
      cfg_sel_bus = VEC[0][(c%4)*16 +: 16]; cfg_idle_bus = 4'hF;
    end
    go_quiet(); repeat (3) @(negedge clk);
    check_vec("R2 enable high ignored", out_words, exp_out());

    // R3: beat data without strobe does nothing
    for (int c = 0; c < 5; c++) drive_beat(1'b0, VEC[4], c % 4);
    go_quiet(); repeat (3) @(negedge clk);
    check_vec("R3 no strobe no load", out_words, exp_out());

    // R8: enable drops after two beats, then returns without strobe
    drive_beat(1'b1, VEC[0], 0);
    drive_beat(1'b0, VEC[0], 1);
    @(negedge clk); cfg_en_n = 1'b1; cfg_sel_bus = VEC[0][47:32];
    @(negedge clk); cfg_sel_bus = VEC[0][63:48];
    drive_beat(1'b0, VEC[0], 2);
    drive_beat(1'b0, VEC[0], 3);
    go_quiet(); repeat (3) @(negedge clk);
    check_vec("R8 aborted load dropped", out_words, exp_out());

    // R9: restart strobe at beat 2 of load A; B must land, A never
    drive_beat(1'b1, VEC[0], 0);
    drive_beat(1'b0, VEC[0], 1);
    drive_beat(1'b1, VEC[3], 0);
    drive_beat(1'b0, VEC[3], 1);
    drive_beat(1'b0, VEC[3], 2);
    drive_beat(1'b0, VEC[3], 3);
    go_quiet();
    check_vec("R9 no commit at old load end", out_words, exp_out());
    @(negedge clk);
    check_vec("R9 old map before restarted commit", out_words, exp_out());
    model_load(VEC[3]);
    @(negedge clk);
    check_vec("R9 restarted load applied", out_words, exp_out());

    // R10: input change shows after one edge; idle outputs unaffected (R6)
    begin
      logic [255:0] prev;
      prev = exp_out();
      set_inputs(8'h77);
      check_vec("R10 no change before edge", out_words, prev);
      @(negedge clk);
      check_vec("R10 new inputs after one edge", out_words, exp_out());
      check_vec("R6 idle word on output 15", out_words[255:240], IDLE);
    end

    // R7: reset in mid-run restores identity
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check_vec("R7 outputs cleared", out_words, '0);
    rst = 1'b0; model_identity();
    @(negedge clk);
    check_vec("R7 identity after mid-run reset", out_words, exp_out());

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic load_model_dummy();
    // model already holds the last table map; nothing to change
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule